// File: doc/BRIEF.md
# Debounced Matrix Key Scanner

This block watches a key matrix of six drive rows and five sense columns and reports the pressed keys to a host as a 30-bit map. While nothing is pressed it holds a static pattern on the rows and does no scanning. The first column that reads high starts a measurement window of 800 base ticks. In that window each row is driven alone, in order, for 64 ticks, and the whole six-row pass runs twice. If both passes give the same non-empty map, the map is latched and an active-low read request goes out. If the passes differ, the window starts again. If both passes are empty, the block goes back to idle.

The host answers a request by pulsing a read-done strobe. That clears the request and starts a new window at once, so the block keeps scanning until every key is released. Two controls shape the rows. A two-bit sleep code picks which rows stay high while idle, so that a key on one of those rows can wake the part. A two-bit row-use code hands the first one or two rows to another function. An oscillator-enable output tells the clock source when the tick may stop.

Top module: `keymx_scanner`

## Requirements
- R1: A low `rst_n` at a clock edge stops any scan and returns the block to idle. On the following cycle `req_n` is 1 and `key_map` is all zero.
- R2: When idle with `sleep_code` = 0, every row open to keys is driven high. Any high column then starts a window on the next clock edge, whether or not `tick` is high.
- R3: When idle with a non-zero `sleep_code`, the rows driven high are these (row 1 is bit 0 of `row_drive`): code 1 gives row 6 only, code 2 gives rows 5 and 6, and code 3 gives rows 2 to 6.
- R4: During a window's two passes, exactly one row is high at a time. Each row holds for 64 ticks, in the order row 1 to row 6. The columns are sampled on the 64th tick of each row. A key on row r (1..6) and column c (1..5) sets `key_map` bit (r-1)*5+c-1.
- R5: If both passes agree and are non-zero, `req_n` falls on the 800th tick counted after the window starts, and `key_map` loads in the same cycle. `req_n` then stays low and `key_map` stays steady until a read-done pulse.
- R6: If the two passes disagree, a new 800-tick window starts without a request. A key held across both passes only from the second window on is therefore reported on tick 1600. A press shorter than one pass is never reported.
- R7: With `row_mode` = 1, row 1 is never driven and its keys read as 0. With `row_mode` = 2 or 3, rows 1 and 2 are never driven and their keys read as 0.
- R8: `osc_en` is 0 only while idle with a non-zero `sleep_code`. A press on a row that is high in that state starts a window. A press on a row that is low does not.
- R9: A `read_done` pulse while `req_n` is 0 sets `req_n` to 1 on the next cycle and starts a new window. A `read_done` pulse outside a request has no effect.
- R10: A window whose two passes are both empty returns the block to idle without a request, and `key_map` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Base time-unit enable, one clock wide |
| col_in | input | 5 | Sense columns, high when a pressed key meets a driven row |
| read_done | input | 1 | Host has finished reading the key map |
| sleep_code | input | 2 | 0 = normal; 1..3 = sleep with a reduced set of high rows |
| row_mode | input | 2 | 0 = all rows scan; 1 = row 1 given away; 2/3 = rows 1 and 2 given away |
| row_drive | output | 6 | Row drive outputs, bit 0 = row 1 |
| req_n | output | 1 | Active-low key read request |
| key_map | output | 30 | Confirmed key map |
| osc_en | output | 1 | Tick source may run |

## Verification
If the window counter is off by even one count, the fall of `req_n` moves away from tick 800. The row outputs also step to the next row one tick early or late. The cycle-level model sees either change on the cycle it happens. If a pass buffer is stale or not cleared, the result shows up at the end of the next window. It appears as a request that is missing, comes at tick 1600 instead of 800, or carries an extra bit in `key_map`. A wrong row mask or sleep pattern is visible on `row_drive` on the very cycle that `row_mode` or `sleep_code` changes.

// File: rtl/keymx_pkg.sv
// Shared types for the matrix key scanner.
package keymx_pkg;
    typedef enum logic [1:0] {
        KM_IDLE = 2'd0,
        KM_SCAN = 2'd1,
        KM_REQ  = 2'd2
    } km_state_e;
endpackage

// File: rtl/keymx_rowdrv.sv
// Row driver: combinational row pattern.
// During a pass it drives the selected row alone. When not scanning it
// drives the idle pattern that the sleep code picks. Rows given to another
// function are always masked low.
// Assumes ROWS >= 3 and row_sel < ROWS.
module keymx_rowdrv #(
    parameter int ROWS = 6,
    localparam int RW = $clog2(ROWS)
) (
    input  logic            drive_en,
    input  logic [RW-1:0]   row_sel,
    input  logic [1:0]      sleep_code,
    input  logic [1:0]      row_mode,
    output logic [ROWS-1:0] row_drive,
    output logic [ROWS-1:0] row_en
);
    logic [RW-1:0] first_high;

    // Pick the lowest row that stays high while idle.
    always_comb begin
        case (sleep_code)
            2'd0:    first_high = '0;
            2'd1:    first_high = RW'(ROWS - 1);
            2'd2:    first_high = RW'(ROWS - 2);
            default: first_high = RW'(1);
        endcase
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        if (r == 0) begin : g_first
            assign row_en[r] = (row_mode == 2'b00);
        end else if (r == 1) begin : g_second
            assign row_en[r] = !row_mode[1];
        end else begin : g_rest
            assign row_en[r] = 1'b1;
        end
        assign row_drive[r] = row_en[r] &
            (drive_en ? (row_sel == RW'(r)) : (RW'(r) >= first_high));
    end
endmodule

// File: rtl/keymx_capture.sv
// Pass capture: keeps one column slice per row for each of the two passes,
// compares the passes, and holds the confirmed key map.
// Assumes sample_en pulses once per row slot and clear comes at window start.
module keymx_capture #(
    parameter int ROWS = 6,
    parameter int COLS = 5,
    localparam int RW = $clog2(ROWS),
    localparam int NK = ROWS * COLS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            sample_en,
    input  logic            second_pass,
    input  logic [RW-1:0]   row_sel,
    input  logic [COLS-1:0] col_in,
    input  logic [ROWS-1:0] row_en,
    input  logic            load_map,
    output logic            agree,
    output logic            nonzero,
    output logic [NK-1:0]   key_map
);
    logic [NK-1:0] flat_a;
    logic [NK-1:0] flat_b;

    for (genvar r = 0; r < ROWS; r++) begin : g_slice
        logic [COLS-1:0] pa;
        logic [COLS-1:0] pb;

        // Store this row's columns into the slice for the current pass.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                pa <= '0;
                pb <= '0;
            end else if (sample_en && row_sel == RW'(r)) begin
                if (second_pass) pb <= col_in & {COLS{row_en[r]}};
                else             pa <= col_in & {COLS{row_en[r]}};
            end
        end
        assign flat_a[r*COLS +: COLS] = pa;
        assign flat_b[r*COLS +: COLS] = pb;
    end

    assign agree   = (flat_a == flat_b);
    assign nonzero = |flat_b;

    // Latch the confirmed map when a request is raised.
    always_ff @(posedge clk) begin
        if (!rst_n)        key_map <= '0;
        else if (load_map) key_map <= flat_b;
    end
endmodule

// File: rtl/keymx_seq.sv
// Window sequencer. It waits for a press, then runs an 800-tick window that
// holds two row passes. At the end of the window it decides: raise the read
// request, rescan, or return to idle. Assumes WINDOW >= 2*ROWS*SLOT and
// SLOT a power of two.
module keymx_seq
    import keymx_pkg::*;
#(
    parameter int ROWS   = 6,
    parameter int SLOT   = 64,
    parameter int WINDOW = 800,
    localparam int RW = $clog2(ROWS),
    localparam int SW = $clog2(SLOT),
    localparam int WW = $clog2(WINDOW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          any_hit,
    input  logic          read_done,
    input  logic          agree,
    input  logic          nonzero,
    output km_state_e     state,
    output logic          drive_en,
    output logic [RW-1:0] row_sel,
    output logic          sample_en,
    output logic          second_pass,
    output logic          clear_bufs,
    output logic          load_map,
    output logic          req_n
);
    logic [WW-1:0] win_cnt;
    logic [SW-1:0] slot_cnt;
    logic [RW-1:0] row_idx;
    logic [1:0]    pass_idx;
    logic          win_last;
    logic          slot_last;
    logic          row_last;
    logic          decide;
    logic          start_win;

    assign win_last    = (win_cnt == WW'(WINDOW - 1));
    assign slot_last   = (slot_cnt == SW'(SLOT - 1));
    assign row_last    = (row_idx == RW'(ROWS - 1));
    assign drive_en    = (state == KM_SCAN) && (pass_idx != 2'd2);
    assign sample_en   = drive_en && tick && slot_last;
    assign second_pass = pass_idx[0];
    assign row_sel     = row_idx;
    assign decide      = (state == KM_SCAN) && tick && win_last;
    assign start_win   = ((state == KM_IDLE) && any_hit) ||
                         (decide && !agree) ||
                         ((state == KM_REQ) && read_done);
    assign clear_bufs  = start_win;
    assign load_map    = decide && agree && nonzero;

    // State and request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KM_IDLE;
            req_n <= 1'b1;
        end else begin
            case (state)
                KM_IDLE: if (any_hit) state <= KM_SCAN;
                KM_SCAN: if (decide && agree) begin
                    state <= nonzero ? KM_REQ : KM_IDLE;
                    req_n <= !nonzero;
                end
                KM_REQ: if (read_done) begin
                    state <= KM_SCAN;
                    req_n <= 1'b1;
                end
                default: state <= KM_IDLE;
            endcase
        end
    end

    // Window, slot, row and pass counters.
    always_ff @(posedge clk) begin
        if (!rst_n || start_win) begin
            win_cnt  <= '0;
            slot_cnt <= '0;
            row_idx  <= '0;
            pass_idx <= '0;
        end else if (state == KM_SCAN && tick && !win_last) begin
            win_cnt <= win_cnt + 1'b1;
            if (drive_en) begin
                if (slot_last) begin
                    slot_cnt <= '0;
                    if (row_last) begin
                        row_idx  <= '0;
                        pass_idx <= pass_idx + 1'b1;
                    end else begin
                        row_idx <= row_idx + 1'b1;
                    end
                end else begin
                    slot_cnt <= slot_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/keymx_scanner.sv
// Top level of the matrix key scanner. It connects the sequencer, the row
// driver and the pass capture. A press is seen as any high column, and the
// tick source may stop while idle in sleep. Assumes col_in is already
// synchronised to clk.
module keymx_scanner
    import keymx_pkg::*;
#(
    parameter int ROWS   = 6,
    parameter int COLS   = 5,
    parameter int SLOT   = 64,
    parameter int WINDOW = 800,
    localparam int RW = $clog2(ROWS),
    localparam int NK = ROWS * COLS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [COLS-1:0] col_in,
    input  logic            read_done,
    input  logic [1:0]      sleep_code,
    input  logic [1:0]      row_mode,
    output logic [ROWS-1:0] row_drive,
    output logic            req_n,
    output logic [NK-1:0]   key_map,
    output logic            osc_en
);
    km_state_e     state;
    logic          drive_en;
    logic [RW-1:0] row_sel;
    logic          sample_en;
    logic          second_pass;
    logic          clear_bufs;
    logic          load_map;
    logic          agree;
    logic          nonzero;
    logic [ROWS-1:0] row_en;

    keymx_seq #(.ROWS(ROWS), .SLOT(SLOT), .WINDOW(WINDOW)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .any_hit(|col_in),
        .read_done(read_done), .agree(agree), .nonzero(nonzero),
        .state(state), .drive_en(drive_en), .row_sel(row_sel),
        .sample_en(sample_en), .second_pass(second_pass),
        .clear_bufs(clear_bufs), .load_map(load_map), .req_n(req_n)
    );

    keymx_rowdrv #(.ROWS(ROWS)) u_rowdrv (
        .drive_en(drive_en), .row_sel(row_sel), .sleep_code(sleep_code),
        .row_mode(row_mode), .row_drive(row_drive), .row_en(row_en)
    );

    keymx_capture #(.ROWS(ROWS), .COLS(COLS)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(clear_bufs), .sample_en(sample_en),
        .second_pass(second_pass), .row_sel(row_sel), .col_in(col_in),
        .row_en(row_en), .load_map(load_map), .agree(agree),
        .nonzero(nonzero), .key_map(key_map)
    );

    // The tick may stop only while idle in a sleep state.
    assign osc_en = !((state == KM_IDLE) && (sleep_code != 2'b00));
endmodule

// File: rtl/keymx_scanner_chk.sv
// Property checker for keymx_scanner, attached with bind below.
module keymx_scanner_chk #(
    parameter int ROWS = 6,
    parameter int COLS = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 read_done,
    input logic [1:0]           row_mode,
    input logic [ROWS-1:0]      row_drive,
    input logic                 req_n,
    input logic [ROWS*COLS-1:0] key_map,
    input logic                 osc_en,
    input logic                 drive_en
);
    // R1: reset leaves the request inactive and the map empty.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (req_n && key_map == '0));

    // R4: at most one row is high during a pass.
    a_r4_single_row: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> $onehot0(row_drive));

    // R5: a request always carries a non-empty map.
    a_r5_req_has_keys: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> (key_map != '0));

    // R5: the request and the map hold until the host reads.
    a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && !read_done) |=> (!req_n && $stable(key_map)));

    // R7: the first row stays low whenever it is given away.
    a_r7_first_row_low: assert property (@(posedge clk) disable iff (!rst_n)
        (row_mode != 2'b00) |-> !row_drive[0]);

    // R7: both shared rows stay low in the two-row mode.
    a_r7_shared_rows_low: assert property (@(posedge clk) disable iff (!rst_n)
        row_mode[1] |-> (row_drive[1:0] == 2'b00));

    // R9: a read during a request releases it on the next cycle.
    a_r9_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && read_done) |=> req_n);

    // R8: a stopped tick means no request and no pass in progress.
    a_r8_osc_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (req_n && !drive_en));
endmodule

bind keymx_scanner keymx_scanner_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .read_done(read_done), .row_mode(row_mode),
    .row_drive(row_drive), .req_n(req_n), .key_map(key_map),
    .osc_en(osc_en), .drive_en(drive_en)
);

// File: tb/keymx_scanner_bench.sv
// Bench: a behavioural key matrix, a cycle-level reference model compared
// on every clock, and directed checks for each requirement.
module keymx_scanner_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        read_done = 1'b0;
    logic [1:0]  sleep_code = 2'd0;
    logic [1:0]  row_mode = 2'd0;
    logic [29:0] pressed = '0;
    logic [4:0]  col_in;
    logic [5:0]  row_drive;
    logic        req_n;
    logic [29:0] key_map;
    logic        osc_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keymx_scanner u_keymx_scanner (
        .clk(clk), .rst_n(rst_n), .tick(tick), .col_in(col_in),
        .read_done(read_done), .sleep_code(sleep_code), .row_mode(row_mode),
        .row_drive(row_drive), .req_n(req_n), .key_map(key_map), .osc_en(osc_en)
    );

    // Key matrix: a column is high when a pressed key meets a high row.
    always_comb begin
        col_in = '0;
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < 5; c++)
                if (row_drive[r] && pressed[r*5+c]) col_in[c] = 1'b1;
    end

    // ---------------- reference model ----------------
    function automatic logic [5:0] f_en(input logic [1:0] rm);
        if (rm[1]) return 6'b111100;
        if (rm == 2'd1) return 6'b111110;
        return 6'b111111;
    endfunction

    function automatic logic [5:0] f_idle(input logic [1:0] sc);
        case (sc)
            2'd0: return 6'b111111;
            2'd1: return 6'b100000;
            2'd2: return 6'b110000;
            default: return 6'b111110;
        endcase
    endfunction

    int          m_state = 0;   // 0 idle, 1 scanning, 2 request
    int          m_win = 0;
    logic        m_reqn = 1'b1;
    logic [29:0] m_map = '0;
    logic [29:0] m_a = '0;
    logic [29:0] m_b = '0;

    function automatic logic [5:0] f_rows(input int st, input int win,
                                          input logic [1:0] sc, input logic [1:0] rm);
        if (st == 1 && win < 768) return (6'b1 << ((win % 384) / 64)) & f_en(rm);
        return f_idle(sc) & f_en(rm);
    endfunction

    function automatic logic [4:0] f_cols(input logic [5:0] rw, input logic [29:0] pk);
        logic [4:0] cl = '0;
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < 5; c++)
                if (rw[r] && pk[r*5+c]) cl[c] = 1'b1;
        return cl;
    endfunction

    // Advance the model on each clock edge from the pre-edge inputs.
    always @(posedge clk) begin
        logic [5:0] rw;
        logic [4:0] cl;
        rw = f_rows(m_state, m_win, sleep_code, row_mode);
        cl = f_cols(rw, pressed);
        if (!rst_n) begin
            m_state = 0; m_win = 0; m_reqn = 1'b1; m_map = '0; m_a = '0; m_b = '0;
        end else if (m_state == 0) begin
            if (cl != 0) begin m_state = 1; m_win = 0; m_a = '0; m_b = '0; end
        end else if (m_state == 1) begin
            if (tick) begin
                if (m_win < 768 && m_win % 64 == 63) begin
                    for (int c = 0; c < 5; c++) begin
                        if (m_win < 384) m_a[((m_win % 384) / 64)*5 + c] = cl[c];
                        else             m_b[((m_win % 384) / 64)*5 + c] = cl[c];
                    end
                end
                if (m_win == 799) begin
                    if (m_a == m_b) begin
                        if (m_b != 0) begin m_state = 2; m_reqn = 1'b0; m_map = m_b; end
                        else m_state = 0;
                    end else begin
                        m_win = 0; m_a = '0; m_b = '0;
                    end
                end else begin
                    m_win = m_win + 1;
                end
            end
        end else begin
            if (read_done) begin
                m_state = 1; m_win = 0; m_a = '0; m_b = '0; m_reqn = 1'b1;
            end
        end
    end

    task automatic check(input string tag, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the design against the model shortly after every edge.
    always @(posedge clk) begin
        logic [5:0] er;
        #1;
        if (!done) begin
            er = f_rows(m_state, m_win, sleep_code, row_mode);
            check("R4 row_drive vs model", row_drive === er, row_drive, er);
            check("R5 req_n vs model", req_n === m_reqn, req_n, m_reqn);
            check("R5 key_map vs model", key_map === m_map, key_map, m_map);
            check("R8 osc_en vs model",
                  osc_en === !(m_state == 0 && sleep_code != 0),
                  osc_en, !(m_state == 0 && sleep_code != 0));
        end
    end

    // ---------------- stimulus ----------------
    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pass the window start edge, then count ticks until req_n falls.
    task automatic start_wait(input bit rd, input int limit, input int add_at,
                              input logic [29:0] add_keys, output int n);
        if (rd) read_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        read_done = 1'b0;
        n = 0;
        while (n <= limit) begin
            @(posedge clk);
            if (tick) n++;
            #1;
            if (n == add_at) pressed = pressed | add_keys;
            if (!req_n) break;
        end
        @(negedge clk);
    endtask

    initial begin
        int n;
        int lows;
        clks(4);
        rst_n = 1'b1;
        clks(2);
        check("R1 reset req_n", req_n === 1'b1, req_n, 1);
        check("R1 reset key_map", key_map === '0, key_map, 0);
        check("R2 idle rows all high", row_drive === 6'h3F, row_drive, 6'h3F);

        // R5 / R4: row 3 column 2 is bit 11, reported on tick 800.
        pressed = 30'd1 << 11;
        start_wait(0, 2000, -1, '0, n);
        check("R5 request on tick 800", n == 800, n, 800);
        check("R4 bit of row3 col2", key_map === (30'd1 << 11), key_map, 30'd1 << 11);

        // R9: reading while held starts another window.
        start_wait(1, 2000, -1, '0, n);
        check("R9 rescan after read", n == 800, n, 800);

        // R10: released keys give an empty window, back to idle.
        pressed = '0;
        start_wait(1, 1000, -1, '0, n);
        check("R10 no request when empty", n > 1000, n, 1001);
        check("R10 idle rows again", row_drive === 6'h3F, row_drive, 6'h3F);
        check("R10 map retained", key_map === (30'd1 << 11), key_map, 30'd1 << 11);

        // R9: read_done outside a request is ignored.
        read_done = 1'b1; clks(1); read_done = 1'b0; clks(20);
        check("R9 stray read keeps idle rows", row_drive === 6'h3F, row_drive, 6'h3F);
        check("R9 stray read no request", req_n === 1'b1, req_n, 1);

        // R4: two corner keys at once.
        pressed = (30'd1 << 0) | (30'd1 << 29);
        start_wait(0, 2000, -1, '0, n);
        check("R4 corner keys", key_map === ((30'd1 << 0) | (30'd1 << 29)),
              key_map, (30'd1 << 0) | (30'd1 << 29));
        pressed = '0;
        start_wait(1, 1000, -1, '0, n);

        // R6: a short press is never reported.
        pressed = 30'd1;
        clks(300);
        pressed = '0;
        lows = 0;
        for (int i = 0; i < 3600; i++) begin
            @(negedge clk);
            if (!req_n) lows++;
        end
        check("R6 short press ignored", lows == 0, lows, 0);
        check("R6 idle after short press", row_drive === 6'h3F, row_drive, 6'h3F);

        // R6: passes disagree, so the request comes on tick 1600.
        pressed = 30'd1;
        start_wait(0, 3000, 400, 30'd1 << 29, n);
        check("R6 request after rescan", n == 1600, n, 1600);
        check("R6 map after rescan", key_map === ((30'd1 << 29) | 30'd1),
              key_map, (30'd1 << 29) | 30'd1);
        pressed = '0;
        start_wait(1, 1000, -1, '0, n);

        // R7: rows 1 and 2 given away.
        row_mode = 2'd2;
        clks(2);
        check("R7 two shared rows low", row_drive === 6'h3C, row_drive, 6'h3C);
        pressed = (30'd1 << 0) | (30'd1 << 10);
        start_wait(0, 2000, -1, '0, n);
        check("R7 shared row keys zero", key_map === (30'd1 << 10), key_map, 30'd1 << 10);
        pressed = '0;
        start_wait(1, 1000, -1, '0, n);

        // R7: row 1 only given away.
        row_mode = 2'd1;
        clks(2);
        check("R7 first row low", row_drive === 6'h3E, row_drive, 6'h3E);
        pressed = (30'd1 << 0) | (30'd1 << 5);
        start_wait(0, 2000, -1, '0, n);
        check("R7 first row keys zero", key_map === (30'd1 << 5), key_map, 30'd1 << 5);
        pressed = '0;
        start_wait(1, 1000, -1, '0, n);
        row_mode = 2'd0;

        // R3: idle sleep patterns, with the tick stopped (R8).
        sleep_code = 2'd1; clks(2);
        check("R3 sleep code 1 rows", row_drive === 6'h20, row_drive, 6'h20);
        check("R8 tick off in sleep", osc_en === 1'b0, osc_en, 0);
        sleep_code = 2'd2; clks(2);
        check("R3 sleep code 2 rows", row_drive === 6'h30, row_drive, 6'h30);
        sleep_code = 2'd3; clks(2);
        check("R3 sleep code 3 rows", row_drive === 6'h3E, row_drive, 6'h3E);

        // R8: only a key on a high row wakes the block.
        sleep_code = 2'd1; clks(2);
        pressed = 30'd1;
        clks(50);
        check("R8 low-row key no wake", osc_en === 1'b0, osc_en, 0);
        pressed = pressed | (30'd1 << 27);
        start_wait(0, 2000, -1, '0, n);
        check("R8 wake and report", key_map === ((30'd1 << 27) | 30'd1),
              key_map, (30'd1 << 27) | 30'd1);
        check("R8 tick on during request", osc_en === 1'b1, osc_en, 1);
        pressed = '0;
        start_wait(1, 1000, -1, '0, n);
        check("R8 still asleep after read", row_drive === 6'h20, row_drive, 6'h20);
        check("R8 tick off again", osc_en === 1'b0, osc_en, 0);

        // R1: reset during a request.
        sleep_code = 2'd0; clks(2);
        pressed = 30'd1 << 3;
        start_wait(0, 2000, -1, '0, n);
        pressed = '0;
        rst_n = 1'b0; clks(1); rst_n = 1'b1; clks(1);
        check("R1 reset drops request", req_n === 1'b1, req_n, 1);
        check("R1 reset clears map", key_map === '0, key_map, 0);

        clks(4);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule